// File: doc/BRIEF.md
# Masked Vector Memory Mover

This unit moves one 256-bit vector register to or from memory under control of a per-element mask. A single start pulse supplies the mask vector, the base address, the direction (load or store), the operation width (128 or 256 bits) and the element size (32 or 64 bits). The unit then walks the enabled lanes in ascending order. It issues one element access at a time on a request/acknowledge memory port and never touches memory for a lane that is masked off.

A load assembles its result in a private accumulator. Disabled lanes read as zero, and a 128-bit operation leaves the upper half of the destination at zero. The destination register is written only when the whole operation succeeds. A store sends the data of each enabled element and leaves every other memory location alone. Two kinds of fault end an operation. A memory fault comes back from an enabled lane's access and reports that lane's index. An alignment fault is decided from the base address alone, whatever the mask holds. A one-cycle done pulse ends every operation, including one whose mask enables no lane.

Top module: `vmask_mover`

## Requirements
- R1: Lane i is enabled only by the most significant bit of mask element i (bit 32i+31 for 32-bit elements, bit 64i+63 for 64-bit elements). All other mask bits have no effect.
- R2: Enabled lanes are accessed in ascending lane order, one request at a time. Lane i uses address base + i*4 (32-bit) or base + i*8 (64-bit). mem_req, mem_addr and mem_we hold steady until mem_ack.
- R3: With op_wide=1 the operation covers 8 lanes of 32 bits or 4 lanes of 64 bits. With op_wide=0 it covers 4 lanes of 32 bits or 2 lanes of 64 bits. Mask bits of lanes outside that range have no effect.
- R4: After a successful load, every disabled lane of result is zero. Enabled 32-bit lanes take mem_rdata[31:0], and enabled 64-bit lanes take all of mem_rdata.
- R5: After a successful 128-bit load, result[255:128] is zero.
- R6: An operation that enables no lane and has an aligned base issues no request and pulses done with fault=0. A load of this kind sets result to zero.
- R7: A store writes only the enabled lanes. mem_we=1 during a store. mem_qword gives the access size. mem_wdata[31:0] (32-bit) or mem_wdata[63:0] (64-bit) carries store_vec element i.
- R8: When an enabled lane's access returns mem_fault with mem_ack, no further request is issued. done pulses with fault=1, fault_align=0 and fault_lane set to that lane's index, and result keeps its previous value.
- R9: A base address that is not a multiple of the element size gives done with fault=1 and fault_align=1. No request is issued and result is unchanged, for any mask, including all-zero.
- R10: done is a single-cycle pulse at completion. A start that arrives while busy=1 is ignored.
- R11: After reset, busy, done, fault, fault_align and mem_req are 0 and result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken while idle) |
| op_store | input | 1 | 1 = store, 0 = load |
| op_wide | input | 1 | 1 = 256-bit, 0 = 128-bit |
| op_qword | input | 1 | 1 = 64-bit elements, 0 = 32-bit |
| mask_vec | input | 256 | Mask operand |
| store_vec | input | 256 | Source vector for stores |
| base_addr | input | AW | Base byte address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last operation ended in a fault |
| fault_align | output | 1 | The fault was an alignment fault |
| fault_lane | output | 3 | Lane index of a memory fault |
| result | output | 256 | Destination register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_qword | output | 1 | Access is 8 bytes (else 4) |
| mem_addr | output | AW | Access byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Access accepted or completed |
| mem_fault | input | 1 | Access faulted (valid with mem_ack) |
| mem_rdata | input | 64 | Read data (valid with mem_ack) |

## Verification
The bench builds the unit with its default 32-bit address width. It confines bases to a 256-byte window so that every lane address, including the last qword lane of a 256-bit operation, lands in a modelled byte memory. Within that window, a poisoned top quarter makes memory faults on any lane reachable. Misaligned bases cover the alignment path, and randomized acknowledge delays exercise request holding.

// File: rtl/vmask_mover.sv
module vmask_mover #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_store,
  input  logic          op_wide,
  input  logic          op_qword,
  input  logic [255:0]  mask_vec,
  input  logic [255:0]  store_vec,
  input  logic [AW-1:0] base_addr,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic          fault_align,
  output logic [2:0]    fault_lane,
  output logic [255:0]  result,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_qword,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_fault,
  input  logic [63:0]   mem_rdata
);
  localparam int NL = 8;
  localparam int QL = NL / 2;

  logic [NL-1:0]  pend_q, en_w, pend_nx;
  logic           st_q, q_q;
  logic [AW-1:0]  base_q;
  logic [255:0]   data_q, acc_q, acc_nx;
  logic [2:0]     lane;
  logic [5:0]     off;
  logic           mis, last;

  always_comb begin
    en_w = '0;
    for (int i = 0; i < QL; i++)
      if (op_qword && (op_wide || i < QL / 2)) en_w[i] = mask_vec[64*i+63];
    for (int i = 0; i < NL; i++)
      if (!op_qword && (op_wide || i < QL)) en_w[i] = mask_vec[32*i+31];
  end

  assign mis = op_qword ? |base_addr[2:0] : |base_addr[1:0];

  always_comb begin
    lane = '0;
    for (int i = NL - 1; i >= 0; i--)
      if (pend_q[i]) lane = 3'(i);
  end

  assign busy      = |pend_q;
  assign mem_req   = busy;
  assign mem_we    = st_q;
  assign mem_qword = q_q;
  assign off       = q_q ? {lane, 3'b000} : {1'b0, lane, 2'b00};
  assign mem_addr  = base_q + AW'(off);
  assign mem_wdata = q_q ? data_q[64*lane[1:0] +: 64] : {32'b0, data_q[32*lane +: 32]};
  assign pend_nx   = pend_q & ~(NL'(1) << lane);
  assign last      = (pend_nx == '0);

  always_comb begin
    acc_nx = acc_q;
    if (q_q) acc_nx[64*lane[1:0] +: 64] = mem_rdata;
    else     acc_nx[32*lane +: 32]      = mem_rdata[31:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0; st_q <= 1'b0; q_q <= 1'b0; base_q <= '0;
      data_q <= '0; acc_q <= '0; result <= '0;
      done <= 1'b0; fault <= 1'b0; fault_align <= 1'b0; fault_lane <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        fault <= 1'b0; fault_align <= 1'b0; fault_lane <= '0;
        st_q <= op_store; q_q <= op_qword; base_q <= base_addr;
        data_q <= store_vec; acc_q <= '0;
        if (mis) begin
          done <= 1'b1; fault <= 1'b1; fault_align <= 1'b1;
        end else if (en_w == '0) begin
          done <= 1'b1;
          if (!op_store) result <= '0;
        end else begin
          pend_q <= en_w;
        end
      end else if (mem_req && mem_ack) begin
        if (mem_fault) begin
          pend_q <= '0; done <= 1'b1; fault <= 1'b1; fault_lane <= lane;
        end else begin
          pend_q <= pend_nx;
          if (!st_q) acc_q <= acc_nx;
          if (last) begin
            done <= 1'b1;
            if (!st_q) result <= acc_nx;
          end
        end
      end
    end
  end

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_fault |=> !mem_req || (mem_addr > $past(mem_addr)));

  a_r8_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_fault |=> !mem_req && fault && done && !fault_align);

  a_r6_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !mis && en_w == '0 |=> !mem_req && done && !fault);

  a_r9_align: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mis |=> !mem_req && done && fault_align);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/test_vmask_mover.sv
module test_vmask_mover;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic start = 0, op_store = 0, op_wide = 0, op_qword = 0;
  logic [255:0] mask_vec = '0, store_vec = '0;
  logic [AW-1:0] base_addr = '0;
  logic busy, done, fault, fault_align, mem_req, mem_we, mem_qword;
  logic [2:0] fault_lane;
  logic [255:0] result;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata;
  logic mem_ack = 0, mem_fault = 0;
  logic [63:0] mem_rdata = '0;

  vmask_mover #(.AW(AW)) i_vmask_mover (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit timeout = 0;
  logic [7:0] mem [0:255];
  logic [7:0] em  [0:255];
  bit poison_on = 0;
  logic [7:0] exp_addr [0:7];
  int n_exp, acc_idx, wait_cnt;
  logic [255:0] exp_res, prev_res;
  bit exp_fault, exp_align;
  logic [2:0] exp_lane;

  function automatic bit poisoned(logic [7:0] a);
    return poison_on && a[7:6] == 2'b11;
  endfunction

  task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !timeout) begin
      timeout = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    mem_ack <= 0; mem_fault <= 0;
    if (mem_req) begin
      if (wait_cnt != 0) wait_cnt--;
      else begin
        logic [7:0] a;
        a = mem_addr[7:0];
        chk(acc_idx < n_exp && exp_addr[acc_idx] == a, "R2 access address", a, acc_idx < n_exp ? exp_addr[acc_idx] : 8'hxx);
        acc_idx++;
        mem_ack <= 1;
        if (poisoned(a)) mem_fault <= 1;
        else if (mem_we) begin
          for (int b = 0; b < (mem_qword ? 8 : 4); b++) mem[8'(a + b)] = mem_wdata[8*b +: 8];
        end else begin
          logic [63:0] d;
          d = {$urandom, $urandom};
          for (int b = 0; b < (mem_qword ? 8 : 4); b++) d[8*b +: 8] = mem[8'(a + b)];
          mem_rdata <= d;
        end
        wait_cnt = $urandom % 3;
      end
    end
  end

  task automatic model(bit st, bit wd, bit q, logic [255:0] m, logic [255:0] sd, logic [7:0] base);
    int nl, esz;
    nl = q ? (wd ? 4 : 2) : (wd ? 8 : 4);
    esz = q ? 8 : 4;
    n_exp = 0; exp_fault = 0; exp_align = 0; exp_lane = 0;
    exp_res = st ? prev_res : '0;
    if (base % esz != 0) begin
      exp_fault = 1; exp_align = 1; exp_res = prev_res; return;
    end
    for (int i = 0; i < nl; i++) begin
      if (m[esz*8*i + esz*8 - 1]) begin
        logic [7:0] a;
        a = 8'(base + i*esz);
        exp_addr[n_exp] = a; n_exp++;
        if (poisoned(a)) begin
          exp_fault = 1; exp_lane = 3'(i); exp_res = prev_res; return;
        end
        for (int b = 0; b < esz; b++)
          if (st) em[8'(a + b)] = sd[esz*8*i + 8*b +: 8];
          else exp_res[esz*8*i + 8*b +: 8] = em[8'(a + b)];
      end
    end
  endtask

  task automatic do_op(bit st, bit wd, bit q, logic [255:0] m, logic [255:0] sd, logic [7:0] base, bit poke);
    int w;
    bit memok;
    model(st, wd, q, m, sd, base);
    acc_idx = 0;
    @(negedge clk);
    start = 1; op_store = st; op_wide = wd; op_qword = q;
    mask_vec = m; store_vec = sd; base_addr = AW'(base);
    @(negedge clk);
    start = 0;
    if (poke && busy) begin
      start = 1; op_store = ~st; mask_vec = '1; base_addr = AW'(base + 4);
      @(negedge clk);
      start = 0;
    end
    w = 0;
    while (!done && !timeout && w < 500) begin @(negedge clk); w++; end
    chk(done, "R10 done seen", done, 1);
    chk(fault == exp_fault, "R8 fault flag", fault, exp_fault);
    chk(fault_align == exp_align, "R9 alignment flag", fault_align, exp_align);
    if (exp_fault && !exp_align) chk(fault_lane == exp_lane, "R8 fault lane", fault_lane, exp_lane);
    chk(result == exp_res, wd ? "R4 result" : "R5 result", result, exp_res);
    chk(acc_idx == n_exp, "R6 access count", acc_idx, n_exp);
    memok = 1;
    for (int i = 0; i < 256; i++) if (mem[i] !== em[i]) memok = 0;
    chk(memok, "R7 memory image", memok, 1);
    prev_res = result;
    @(negedge clk);
    chk(!done && !busy, "R10 done single cycle", done, 0);
  endtask

  initial begin
    logic [255:0] m, d;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'($urandom); em[i] = mem[i]; end
    wait_cnt = 0; n_exp = 0; acc_idx = 0; prev_res = '0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !fault_align && !mem_req && result == '0, "R11 reset state", result, '0);
    rst_n = 1;
    @(negedge clk);
    d = {8{$urandom}};
    // R1: lower bits set, sign bits clear -> nothing happens
    do_op(0, 1, 0, {8{32'h7fff_ffff}}, d, 8'h10, 0);
    chk(result == '0, "R1 lower mask bits ignored", result, '0);
    // R4/R5: full wide load then narrow load clears upper half
    do_op(0, 1, 0, '1, d, 8'h20, 0);
    do_op(0, 0, 1, {128'h0, 64'h8000_0000_0000_0000, 64'h0}, d, 8'h40, 0);
    chk(result[255:128] == '0, "R5 upper half clear", result[255:128], '0);
    // R3: mask bits beyond the narrow range
    do_op(1, 0, 0, {128'hffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff, 128'h0}, d, 8'h60, 0);
    // R7: sparse stores
    do_op(1, 1, 1, {64'h8000_0000_0000_0000, 64'h0, 64'hffff_ffff_ffff_ffff, 64'h0}, d, 8'h80, 0);
    // R9: misaligned with all-zero mask and with full mask
    do_op(0, 1, 0, '0, d, 8'h22, 0);
    do_op(1, 1, 1, '1, d, 8'h24, 0);
    // R8: fault on a middle lane
    poison_on = 1;
    do_op(0, 1, 1, '1, d, 8'hb0, 0);
    // R10: start while busy ignored
    poison_on = 0;
    do_op(0, 1, 0, '1, d, 8'h08, 1);
    for (int n = 0; n < 300 && !timeout; n++) begin
      logic [7:0] base;
      bit q;
      for (int k = 0; k < 8; k++) begin m[32*k +: 32] = $urandom; d[32*k +: 32] = $urandom; end
      if ($urandom % 5 == 0) m = '0;
      q = $urandom % 2;
      base = 8'(($urandom % 28) * 8);
      if ($urandom % 12 == 0) base = base + 8'(1 + $urandom % 3);
      else if (!q && $urandom % 2) base = base + 4;
      poison_on = ($urandom % 4 == 0);
      do_op($urandom % 2, $urandom % 2, q, m, d, base, $urandom % 8 == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule